// File: doc/BRIEF.md
# Soft-Edged Slow PWM Generator

This block drives a resistive heater with a slow on/off waveform, about 30 Hz at the default settings, whose duty comes from a 7-bit input. The load is never switched hard. Each change from off to on becomes a short burst of fast PWM periods whose high time grows step by step. Each change from on to off becomes a mirrored burst whose high time shrinks. The heater current therefore ramps instead of stepping, which keeps the supply quiet.

The block derives two tick rates from the system clock. The fast tick clocks a period timer during the ramps. A slow tick, a fixed number of fast ticks long, clocks the same timer while the output holds steady. A shared 8-bit cycle counter advances once per slow timer period in both hold phases. Because the low hold and the high hold together always use exactly one wrap of that counter, the base period does not depend on the duty.

The duty is doubled and sampled once per base period. Very high duties bypass the ramps and keep the output on. One-tick guard states separate every change between the two rates, so the output holds its level while the timer is reloaded. The duty input is a plain level and needs no handshake. The output is a single registered bit.

Top module: `soft_edge_pwm`

## Requirements
- R1: The compare value is the duty input shifted left by one bit ({duty, 0}). It is loaded only in the one-tick start state that opens each base period, and again at each cycle-counter wrap while the output holds high. A duty change at any other time has no effect until then.
- R2: When the compare value is zero, the output stays low for the whole base period and no ramp is produced.
- R3: One fast period is 2^TMR_W fast ticks. One hold step is SLOW_DIV times 2^TMR_W fast ticks. For any compare value below the full threshold, the base period is 256 hold steps, plus 2 × RAMP_STEPS fast periods, plus four single-tick states. In the bench configuration this is 8708 clocks.
- R4: A rising ramp has RAMP_STEPS fast periods with the step index k running from RAMP_STEPS−1 down to 0. In each period the output is high first, for (RAMP_STEPS−k) × 2^TMR_W/RAMP_STEPS ticks, and low for the rest.
- R5: A falling ramp has RAMP_STEPS fast periods with the same indexing. The output is high first, for k × 2^TMR_W/RAMP_STEPS ticks, and low for the rest, so the last period is entirely low.
- R6: The high hold lasts exactly as many hold steps as the compare value. The low hold lasts until the cycle counter wraps from 255 to 0, and the rising ramp starts at that wrap.
- R7: When the compare value is at or above FULL_TH (253 by default), the block stays in the high hold and the output stays high. The compare value is reloaded at each counter wrap, so a lower duty ends the full-on condition.
- R8: Each guard state lasts one fast tick. The output does not change on entering, during or on leaving a guard state.
- R9: A synchronous reset forces the output low, clears the counters and the compare value, and enters the start state. After reset, the output stays low for at least 256 hold steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_in | input | DUTY_W | Requested duty, sampled once per base period |
| heat_drive | output | 1 | Registered heater drive bit |

## Verification
The hardest case to reach from the ports is a duty change that arrives in the middle of a base period. It must leave the current period untouched and act only on the next one. The stimulus waits for the first rising edge of a ramp and changes the duty at that instant. The bench then checks that the following high hold still has the old length, and that the next period has the new one. Reaching the full-on state and leaving it again also takes several periods of settling. Each duty case therefore waits two base periods and then counts the high clocks over one exact period window.

// File: rtl/soft_edge_pwm_pkg.sv
package soft_edge_pwm_pkg;

  typedef enum logic [2:0] {
    PH_START     = 3'd0,
    PH_LOW_HOLD  = 3'd1,
    PH_GUARD_UP  = 3'd2,
    PH_RAMP_UP   = 3'd3,
    PH_GUARD_HI  = 3'd4,
    PH_HIGH_HOLD = 3'd5,
    PH_RAMP_DN   = 3'd6,
    PH_GUARD_DN  = 3'd7
  } phase_e;

endpackage

// File: rtl/soft_edge_pwm_ticks.sv
module soft_edge_pwm_ticks #(
  parameter int FAST_DIV = 4,
  parameter int SLOW_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_mode,
  output logic tick
);
  localparam int SD_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [SD_W-1:0] SD_LAST = SD_W'(SLOW_DIV - 1);

  logic fast_tick;

  generate
    if (FAST_DIV == 1) begin : g_fast_direct
      assign fast_tick = 1'b1;
    end else begin : g_fast_div
      localparam int FD_W = $clog2(FAST_DIV);
      localparam logic [FD_W-1:0] FD_LAST = FD_W'(FAST_DIV - 1);
      logic [FD_W-1:0] fdiv;
      always_ff @(posedge clk) begin
        if (rst || fdiv == FD_LAST) fdiv <= '0;
        else                        fdiv <= fdiv + 1'b1;
      end
      assign fast_tick = (fdiv == FD_LAST);
    end
  endgenerate

  // Slow divider restarts whenever the fast rate is in use, so every hold
  // phase begins on a whole slow tick.
  logic [SD_W-1:0] sdiv;
  always_ff @(posedge clk) begin
    if (rst || !slow_mode) sdiv <= '0;
    else if (fast_tick)    sdiv <= (sdiv == SD_LAST) ? '0 : sdiv + 1'b1;
  end

  assign tick = slow_mode ? (fast_tick && sdiv == SD_LAST) : fast_tick;

  a_r3_slow_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (slow_mode && tick) |=> !tick || (SLOW_DIV == 1) || !slow_mode);

endmodule

// File: rtl/soft_edge_pwm_seq.sv
module soft_edge_pwm_seq
  import soft_edge_pwm_pkg::*;
#(
  parameter int DUTY_W     = 7,
  parameter int TMR_W      = 8,
  parameter int RAMP_STEPS = 16,
  parameter int FULL_TH    = 253
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                tick,
  input  logic [DUTY_W-1:0]                   duty_in,
  output phase_e                              phase,
  output logic [TMR_W-1:0]                    tmr,
  output logic [$clog2(RAMP_STEPS)-1:0]       step,
  output logic                                slow_mode
);
  localparam int CMP_W  = DUTY_W + 1;
  localparam int STEP_W = $clog2(RAMP_STEPS);
  localparam logic [TMR_W-1:0]  TMR_LAST  = {TMR_W{1'b1}};
  localparam logic [CMP_W-1:0]  SC_LAST   = {CMP_W{1'b1}};
  localparam logic [CMP_W-1:0]  FULL_C    = CMP_W'(FULL_TH);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(RAMP_STEPS - 1);

  logic [CMP_W-1:0] cmp;
  logic [CMP_W-1:0] sc;
  logic [CMP_W-1:0] sc_inc;
  logic [CMP_W-1:0] duty_x2;
  logic             tmr_wrap;

  assign duty_x2  = {duty_in, 1'b0};
  assign sc_inc   = sc + 1'b1;
  assign tmr_wrap = (tmr == TMR_LAST);
  assign slow_mode = (phase == PH_LOW_HOLD) || (phase == PH_HIGH_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_START;
      tmr   <= '0;
      sc    <= '0;
      cmp   <= '0;
      step  <= '0;
    end else if (tick) begin
      unique case (phase)
        PH_START: begin
          cmp   <= duty_x2;
          tmr   <= '0;
          phase <= PH_LOW_HOLD;
        end
        PH_LOW_HOLD: begin
          tmr <= tmr + 1'b1;
          if (tmr_wrap) begin
            sc <= sc_inc;
            if (sc == SC_LAST) phase <= (cmp == '0) ? PH_START : PH_GUARD_UP;
          end
        end
        PH_GUARD_UP: begin
          tmr   <= '0;
          step  <= STEP_LAST;
          phase <= PH_RAMP_UP;
        end
        PH_RAMP_UP: begin
          tmr <= tmr + 1'b1;
          if (tmr_wrap) begin
            if (step == '0) phase <= PH_GUARD_HI;
            else            step  <= step - 1'b1;
          end
        end
        PH_GUARD_HI: begin
          tmr   <= '0;
          phase <= PH_HIGH_HOLD;
        end
        PH_HIGH_HOLD: begin
          tmr <= tmr + 1'b1;
          if (tmr_wrap) begin
            sc <= sc_inc;
            if (sc == SC_LAST) cmp <= duty_x2;
            if (cmp < FULL_C && sc_inc >= cmp) begin
              step  <= STEP_LAST;
              phase <= PH_RAMP_DN;
            end
          end
        end
        PH_RAMP_DN: begin
          tmr <= tmr + 1'b1;
          if (tmr_wrap) begin
            if (step == '0) phase <= PH_GUARD_DN;
            else            step  <= step - 1'b1;
          end
        end
        PH_GUARD_DN: begin
          tmr   <= '0;
          phase <= PH_START;
        end
        default: phase <= PH_START;
      endcase
    end
  end

  // R1: the compare value only moves at a period start or a counter wrap in high hold
  a_r1_cmp_held: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_START && phase != PH_HIGH_HOLD) |=> $stable(cmp));

  // R2: a zero compare value never leads into a rising ramp
  a_r2_zero_no_rise: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOW_HOLD && cmp == '0) |=> phase != PH_GUARD_UP);

  // R7: near-full compare keeps the block in high hold
  a_r7_full_stays: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HIGH_HOLD && cmp >= FULL_C) |=> phase == PH_HIGH_HOLD);

  // R8: guard states last a single tick
  a_r8_guard_single: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_GUARD_UP || phase == PH_GUARD_HI || phase == PH_GUARD_DN) && tick)
      |=> phase != $past(phase));

  // R9: reset returns to the start state with a cleared counter
  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> (phase == PH_START && sc == '0 && cmp == '0));

endmodule

// File: rtl/soft_edge_pwm_shape.sv
module soft_edge_pwm_shape
  import soft_edge_pwm_pkg::*;
#(
  parameter int TMR_W      = 8,
  parameter int RAMP_STEPS = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  phase_e                        phase,
  input  logic [TMR_W-1:0]              tmr,
  input  logic [$clog2(RAMP_STEPS)-1:0] step,
  output logic                          drive_q
);
  localparam int THR_W = TMR_W + 1;
  localparam int SCALE = (1 << TMR_W) / RAMP_STEPS;

  logic [THR_W-1:0] up_thr;
  logic [THR_W-1:0] dn_thr;
  logic [THR_W-1:0] tmr_x;
  logic             level;

  assign up_thr = THR_W'((RAMP_STEPS - int'(step)) * SCALE);
  assign dn_thr = THR_W'(int'(step) * SCALE);
  assign tmr_x  = {1'b0, tmr};

  always_comb begin
    unique case (phase)
      PH_RAMP_UP:                level = (tmr_x < up_thr);
      PH_RAMP_DN:                level = (tmr_x < dn_thr);
      PH_GUARD_HI, PH_HIGH_HOLD: level = 1'b1;
      default:                   level = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else     drive_q <= level;
  end

  // R4: the final rising step ends with the output high
  a_r4_last_rise_high: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RAMP_UP && step == '0) |=> drive_q);

  // R5: the final falling step is entirely low
  a_r5_last_fall_low: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RAMP_DN && step == '0) |=> !drive_q);

  // R8: no output movement across a guard state
  a_r8_guard_quiet: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_GUARD_UP || phase == PH_GUARD_HI || phase == PH_GUARD_DN)
      |=> $stable(drive_q));

  // R9: reset forces the drive low
  a_r9_reset_low: assert property (@(posedge clk) rst |=> !drive_q);

endmodule

// File: rtl/soft_edge_pwm.sv
module soft_edge_pwm
  import soft_edge_pwm_pkg::*;
#(
  parameter int FAST_DIV   = 4,
  parameter int SLOW_DIV   = 8,
  parameter int DUTY_W     = 7,
  parameter int TMR_W      = 8,
  parameter int RAMP_STEPS = 16,
  parameter int FULL_TH    = 253
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] duty_in,
  output logic              heat_drive
);
  localparam int STEP_W = $clog2(RAMP_STEPS);

  logic              tick;
  logic              slow_mode;
  phase_e            phase;
  logic [TMR_W-1:0]  tmr;
  logic [STEP_W-1:0] step;

  soft_edge_pwm_ticks #(
    .FAST_DIV (FAST_DIV),
    .SLOW_DIV (SLOW_DIV)
  ) u_ticks (
    .clk       (clk),
    .rst       (rst),
    .slow_mode (slow_mode),
    .tick      (tick)
  );

  soft_edge_pwm_seq #(
    .DUTY_W     (DUTY_W),
    .TMR_W      (TMR_W),
    .RAMP_STEPS (RAMP_STEPS),
    .FULL_TH    (FULL_TH)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .duty_in   (duty_in),
    .phase     (phase),
    .tmr       (tmr),
    .step      (step),
    .slow_mode (slow_mode)
  );

  soft_edge_pwm_shape #(
    .TMR_W      (TMR_W),
    .RAMP_STEPS (RAMP_STEPS)
  ) u_shape (
    .clk     (clk),
    .rst     (rst),
    .phase   (phase),
    .tmr     (tmr),
    .step    (step),
    .drive_q (heat_drive)
  );

endmodule

// File: tb/tb_soft_edge_pwm.sv
module tb_soft_edge_pwm;
  localparam int TMR_W    = 4;
  localparam int SLOW_DIV = 2;
  localparam int RAMP     = 16;
  localparam int FP       = 1 << TMR_W;
  localparam int STEP_CLK = SLOW_DIV * FP;
  localparam int PERIOD   = 256 * STEP_CLK + 2 * RAMP * FP + 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] duty = 7'd64;
  logic       drive;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  soft_edge_pwm #(
    .FAST_DIV   (1),
    .SLOW_DIV   (SLOW_DIV),
    .DUTY_W     (7),
    .TMR_W      (TMR_W),
    .RAMP_STEPS (RAMP),
    .FULL_TH    (253)
  ) dut (
    .clk        (clk),
    .rst        (rst),
    .duty_in    (duty),
    .heat_drive (drive)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (drive === lvl) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Starts at the negedge where a rising ramp has just begun.
  task automatic ramp_cycle(input int exp_hold_hi, input int exp_low, input string tag);
    int h;
    int l;
    int total;
    total = 0;
    for (int j = 1; j < RAMP; j++) begin
      run_len(1'b1, h); check({tag, " R4 rise high"}, h, j);
      run_len(1'b0, l); check({tag, " R4 rise low"}, l, RAMP - j);
      total += h + l;
    end
    run_len(1'b1, h); check({tag, " R6 hold high"}, h, exp_hold_hi);
    total += h;
    for (int m = 1; m < RAMP - 1; m++) begin
      run_len(1'b0, l); check({tag, " R5 fall low"}, l, m);
      run_len(1'b1, h); check({tag, " R5 fall high"}, h, RAMP - 1 - m);
      total += h + l;
    end
    run_len(1'b0, l); check({tag, " R6 hold low"}, l, exp_low);
    total += l;
    check({tag, " R3 period"}, total, PERIOD);
  endtask

  task automatic total_high(input logic [6:0] d, input string tag);
    int h;
    int exp;
    duty = d;
    repeat (2 * PERIOD) @(negedge clk);
    h = 0;
    repeat (PERIOD) begin
      if (drive) h++;
      @(negedge clk);
    end
    if (d == 0)             exp = 0;
    else if (2 * d >= 253)  exp = PERIOD;
    else                    exp = 257 + 64 * int'(d);
    check(tag, h, exp);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int l;
    repeat (3) @(negedge clk);
    check("R9 reset output low", int'(drive), 0);
    rst = 1'b0;
    @(negedge clk);
    run_len(1'b0, l);
    check("R9 low after reset spans 256 steps", int'(l >= 256 * STEP_CLK), 1);

    // Steady duty 64: compare 128
    ramp_cycle(32 + 128 * STEP_CLK, 34 + 128 * STEP_CLK, "d64");

    // R1: change duty at the first rising edge; the running period keeps compare 128
    duty = 7'd1;
    ramp_cycle(32 + 128 * STEP_CLK, 34 + 128 * STEP_CLK, "R1 mid-period change ignored");
    ramp_cycle(32 + 2 * STEP_CLK, 34 + 254 * STEP_CLK, "R1 change applied next period");

    total_high(7'd0,   "R2 duty 0 total high");
    total_high(7'd1,   "R3 duty 1 total high");
    total_high(7'd127, "R7 duty 127 full on");
    total_high(7'd0,   "R7 leave full on to duty 0");
    total_high(7'd126, "R7 duty 126 below threshold");

    while (drive !== 1'b1) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 mid-run reset forces low", int'(drive), 0);
    rst = 1'b0;
    repeat (100) @(negedge clk);
    check("R9 stays low after reset", int'(drive), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule